// File: doc/BRIEF.md
# Port Command Engine and Slot Scheduler

This block is the per-port control core of a storage host port. It owns the port command register. On every host write to that register it keeps the read-only status fields, forces the interface-state request field to zero, and steps two engines. The command-list engine moves from requested to running, and the receive-area engine moves from enabled to running. Each engine reaches its running state only when its base address passes a validity check; a failed check withdraws the request and raises a one-cycle error pulse.

The block also holds the command-issue vector. Host writes set bits in it by OR-merge. While the list engine is started, the block presents the lowest pending slot to a downstream command handler over a valid/ready handshake. A slot accepted as queued is retired at once. A slot accepted as non-queued becomes the busy slot and blocks further dispatch until the device reports neither BSY nor DRQ. The first command-register write that leaves the receive engine running after a port reset produces a single request for the initial device-to-host register frame.

Top module: `port_cmd_engine`

## Requirements
- R1: After reset, cmd_reg and issue_vec are zero and disp_valid, busy_hold, list_err, fis_err and d2h_req are low.
- R2: A command-register write keeps bits 15:8 at their previous values and forces bits 31:28 to zero. Every other bit takes the written value, subject to R3 and R5.
- R3: When a write leaves bit 0 (start) set while bit 15 (list running) is clear, a valid clb_base sets bit 15. A clb_base is valid when it is nonzero with its low 10 bits zero. Otherwise bit 0 is cleared and list_err pulses high for exactly the cycle after the write.
- R4: A write that clears bit 0 while bit 15 is set clears bit 15.
- R5: Bit 4 (receive enable) and bit 14 (receive running) follow the same rules as R3 and R4. They use fis_base, which is valid when it is nonzero with its low 8 bits zero, and they report failure on fis_err.
- R6: d2h_req pulses for one cycle after the first command-register write that leaves bit 14 set following reset or a port reset. Later writes raise no request.
- R7: disp_valid is high only while bit 0 is set, issue_vec is nonzero and no slot is busy. disp_slot is then the lowest-numbered set bit of issue_vec.
- R8: issue_wr_data is OR-merged into issue_vec. A bit is never cleared except by the completion of its own slot.
- R9: A handshake (disp_valid and disp_ready) with disp_queued high clears that slot's issue bit at the accepting edge.
- R10: A handshake with disp_queued low makes the slot busy (busy_hold high). Its issue bit stays set and dispatch stops until an edge sampled with dev_bsy and dev_drq both low. That edge clears the bit and releases the hold.
- R11: A port_reset pulse releases the busy slot without clearing its issue bit, and re-arms the request of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_reset | input | 1 | Port-level reset pulse |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_data | input | 32 | Command register write value |
| clb_base | input | ADDR_W | Command-list base address |
| fis_base | input | ADDR_W | Receive-area base address |
| issue_wr_en | input | 1 | Command-issue write strobe |
| issue_wr_data | input | SLOTS | Slots to add to the issue vector |
| dev_bsy | input | 1 | Device status BSY |
| dev_drq | input | 1 | Device status DRQ |
| disp_ready | input | 1 | Handler accepts the offered slot |
| disp_queued | input | 1 | Accepted command is a queued one |
| cmd_reg | output | 32 | Command register value |
| issue_vec | output | SLOTS | Pending command-issue vector |
| disp_valid | output | 1 | A slot is offered to the handler |
| disp_slot | output | $clog2(SLOTS) | Offered slot index |
| busy_hold | output | 1 | A non-queued slot is in progress |
| list_err | output | 1 | List engine start failed (pulse) |
| fis_err | output | 1 | Receive engine start failed (pulse) |
| d2h_req | output | 1 | Initial device-to-host frame request (pulse) |

## Verification
The engines are driven with an all-ones write, with zero, misaligned and aligned base addresses, and with start and stop writes. These patterns separate the field protection, the validity test for each alignment and the running-bit handshake. Issue vectors with several bits set, plus a lower bit added while a higher slot is offered, show whether selection is lowest-first and whether merging loses bits. Queued and non-queued acceptances under BSY and DRQ in turn separate immediate retirement from the busy hold. A port reset during a hold shows that the slot is released while its issue bit is kept.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int CMD_W   = 32;
  localparam int B_START = 0;
  localparam int B_FRE   = 4;
  localparam int B_FRUN  = 14;
  localparam int B_LRUN  = 15;
  localparam logic [CMD_W-1:0] RO_MASK  = 32'h0000_FF00;
  localparam logic [CMD_W-1:0] ICC_MASK = 32'hF000_0000;

  typedef struct packed {
    logic req;
    logic run;
    logic err;
  } eng_t;

  // Protected fields keep old value, request field forced to zero.
  function automatic logic [CMD_W-1:0] merge_cmd(input logic [CMD_W-1:0] old_v,
                                                 input logic [CMD_W-1:0] new_v);
    return (old_v & RO_MASK) | (new_v & ~(RO_MASK | ICC_MASK));
  endfunction

  // Nonzero and aligned to 2**lg bytes.
  function automatic logic base_ok(input logic [63:0] a, input int unsigned lg);
    logic [63:0] m;
    m = (64'd1 << lg) - 64'd1;
    return (a != 64'd0) && ((a & m) == 64'd0);
  endfunction

  // One engine step: request/running handshake gated by address validity.
  function automatic eng_t eng_step(input logic req, input logic run, input logic ok);
    eng_t r;
    r.req = req;
    r.run = run;
    r.err = 1'b0;
    if (req && !run) begin
      if (ok) r.run = 1'b1;
      else begin
        r.req = 1'b0;
        r.err = 1'b1;
      end
    end else if (!req && run) begin
      r.run = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/pce_cmd_ctrl.sv
module pce_cmd_ctrl
  import pce_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_reset,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             clb_ok,
  input  logic             fis_ok,
  output logic [CMD_W-1:0] cmd_q,
  output logic             list_err,
  output logic             fis_err,
  output logic             d2h_req
);
  logic [CMD_W-1:0] cmd_n;
  logic             le_n, fe_n;
  logic             init_sent;
  eng_t             list_s, fis_s;

  always_comb begin
    cmd_n  = merge_cmd(cmd_q, wr_data);
    list_s = eng_step(cmd_n[B_START], cmd_q[B_LRUN], clb_ok);
    fis_s  = eng_step(cmd_n[B_FRE], cmd_q[B_FRUN], fis_ok);
    cmd_n[B_START] = list_s.req;
    cmd_n[B_LRUN]  = list_s.run;
    cmd_n[B_FRE]   = fis_s.req;
    cmd_n[B_FRUN]  = fis_s.run;
    le_n = list_s.err;
    fe_n = fis_s.err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      list_err  <= 1'b0;
      fis_err   <= 1'b0;
      d2h_req   <= 1'b0;
      init_sent <= 1'b0;
    end else begin
      list_err <= 1'b0;
      fis_err  <= 1'b0;
      d2h_req  <= 1'b0;
      if (port_reset) init_sent <= 1'b0;
      if (wr_en) begin
        cmd_q    <= cmd_n;
        list_err <= le_n;
        fis_err  <= fe_n;
        if (cmd_n[B_FRUN] && !init_sent) begin
          d2h_req   <= 1'b1;
          init_sent <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pce_slot_sched.sv
module pce_slot_sched #(
  parameter int SLOTS = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_reset,
  input  logic             start,
  input  logic             iss_wr_en,
  input  logic [SLOTS-1:0] iss_wr_data,
  input  logic             disp_ready,
  input  logic             disp_queued,
  input  logic             dev_bsy,
  input  logic             dev_drq,
  output logic [SLOTS-1:0] issue_q,
  output logic             disp_valid,
  output logic [SW-1:0]    disp_slot,
  output logic             busy_hold
);
  logic [SW-1:0]    busy_slot;
  logic [SLOTS-1:0] clr_mask;
  logic             accept, take_queued, take_busy, release_ev;

  function automatic logic [SW-1:0] lowest_set(input logic [SLOTS-1:0] v);
    logic [SW-1:0] idx;
    idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (v[i]) idx = SW'(i);
    end
    return idx;
  endfunction

  assign disp_valid  = start && (|issue_q) && !busy_hold;
  assign disp_slot   = lowest_set(issue_q);
  assign accept      = disp_valid && disp_ready;
  assign take_queued = accept && disp_queued;
  assign take_busy   = accept && !disp_queued;
  assign release_ev  = busy_hold && !dev_bsy && !dev_drq;

  always_comb begin
    clr_mask = '0;
    if (take_queued) clr_mask[disp_slot] = 1'b1;
    if (release_ev)  clr_mask[busy_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_q   <= '0;
      busy_hold <= 1'b0;
      busy_slot <= '0;
    end else begin
      issue_q <= (issue_q & ~clr_mask) | (iss_wr_en ? iss_wr_data : '0);
      if (port_reset) begin
        busy_hold <= 1'b0;
      end else if (take_busy) begin
        busy_hold <= 1'b1;
        busy_slot <= disp_slot;
      end else if (release_ev) begin
        busy_hold <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/port_cmd_engine.sv
module port_cmd_engine
  import pce_pkg::*;
#(
  parameter int SLOTS        = 32,
  parameter int ADDR_W       = 64,
  parameter int CLB_ALIGN_LG = 10,
  parameter int FIS_ALIGN_LG = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_reset,
  input  logic              cmd_wr_en,
  input  logic [31:0]       cmd_wr_data,
  input  logic [ADDR_W-1:0] clb_base,
  input  logic [ADDR_W-1:0] fis_base,
  input  logic              issue_wr_en,
  input  logic [SLOTS-1:0]  issue_wr_data,
  input  logic              dev_bsy,
  input  logic              dev_drq,
  input  logic              disp_ready,
  input  logic              disp_queued,
  output logic [31:0]       cmd_reg,
  output logic [SLOTS-1:0]  issue_vec,
  output logic              disp_valid,
  output logic [SW-1:0]     disp_slot,
  output logic              busy_hold,
  output logic              list_err,
  output logic              fis_err,
  output logic              d2h_req
);
  logic clb_ok, fis_ok;

  assign clb_ok = base_ok(64'(clb_base), CLB_ALIGN_LG);
  assign fis_ok = base_ok(64'(fis_base), FIS_ALIGN_LG);

  pce_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_reset(port_reset),
    .wr_en    (cmd_wr_en),
    .wr_data  (cmd_wr_data),
    .clb_ok   (clb_ok),
    .fis_ok   (fis_ok),
    .cmd_q    (cmd_reg),
    .list_err (list_err),
    .fis_err  (fis_err),
    .d2h_req  (d2h_req)
  );

  pce_slot_sched #(.SLOTS(SLOTS)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_reset (port_reset),
    .start      (cmd_reg[B_START]),
    .iss_wr_en  (issue_wr_en),
    .iss_wr_data(issue_wr_data),
    .disp_ready (disp_ready),
    .disp_queued(disp_queued),
    .dev_bsy    (dev_bsy),
    .dev_drq    (dev_drq),
    .issue_q    (issue_vec),
    .disp_valid (disp_valid),
    .disp_slot  (disp_slot),
    .busy_hold  (busy_hold)
  );
endmodule

// File: rtl/port_cmd_engine_chk.sv
module port_cmd_engine_chk #(
  parameter int SLOTS = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             port_reset,
  input logic             cmd_wr_en,
  input logic             st,
  input logic             fre,
  input logic             lrun,
  input logic             frun,
  input logic [5:0]       ro_f,
  input logic [SLOTS-1:0] issue_vec,
  input logic             disp_valid,
  input logic [SW-1:0]    disp_slot,
  input logic             disp_ready,
  input logic             busy_hold,
  input logic             dev_bsy,
  input logic             dev_drq,
  input logic             list_err,
  input logic             fis_err,
  input logic             d2h_req
);
  a_r2_ro_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_en |=> ro_f == $past(ro_f));

  a_r3_err_drops_start: assert property (@(posedge clk) disable iff (!rst_n)
    list_err |-> !st && !lrun);

  a_r3_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lrun) |-> st);

  a_r5_err_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    fis_err |-> !fre && !frun);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    d2h_req |=> !d2h_req);

  a_r6_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    d2h_req |-> frun);

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (st && (issue_vec != '0) && !busy_hold));

  a_r7_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (issue_vec[disp_slot] &&
      ((issue_vec & ((SLOTS'(1) << disp_slot) - SLOTS'(1))) == '0)));

  a_r8_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (!(disp_valid && disp_ready) && !busy_hold) |=>
      (($past(issue_vec) & ~issue_vec) == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_hold && (dev_bsy || dev_drq) && !port_reset) |=> busy_hold);

  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    port_reset |=> !busy_hold);
endmodule

bind port_cmd_engine port_cmd_engine_chk #(.SLOTS(SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .port_reset(port_reset),
  .cmd_wr_en (cmd_wr_en),
  .st        (cmd_reg[0]),
  .fre       (cmd_reg[4]),
  .lrun      (cmd_reg[15]),
  .frun      (cmd_reg[14]),
  .ro_f      (cmd_reg[13:8]),
  .issue_vec (issue_vec),
  .disp_valid(disp_valid),
  .disp_slot (disp_slot),
  .disp_ready(disp_ready),
  .busy_hold (busy_hold),
  .dev_bsy   (dev_bsy),
  .dev_drq   (dev_drq),
  .list_err  (list_err),
  .fis_err   (fis_err),
  .d2h_req   (d2h_req)
);

// File: tb/port_cmd_engine_test.sv
module port_cmd_engine_test;
  localparam int CLK_P = 10;
  localparam int SLOTS = 32;
  localparam int WD_CYC = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_reset = 1'b0;
  logic        cmd_wr_en = 1'b0;
  logic [31:0] cmd_wr_data = '0;
  logic [63:0] clb_base = '0;
  logic [63:0] fis_base = '0;
  logic        issue_wr_en = 1'b0;
  logic [31:0] issue_wr_data = '0;
  logic        dev_bsy = 1'b0;
  logic        dev_drq = 1'b0;
  logic        disp_ready = 1'b0;
  logic        disp_queued = 1'b0;
  logic [31:0] cmd_reg;
  logic [31:0] issue_vec;
  logic        disp_valid;
  logic [4:0]  disp_slot;
  logic        busy_hold;
  logic        list_err;
  logic        fis_err;
  logic        d2h_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  port_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .port_reset(port_reset),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .clb_base(clb_base), .fis_base(fis_base),
    .issue_wr_en(issue_wr_en), .issue_wr_data(issue_wr_data),
    .dev_bsy(dev_bsy), .dev_drq(dev_drq),
    .disp_ready(disp_ready), .disp_queued(disp_queued),
    .cmd_reg(cmd_reg), .issue_vec(issue_vec),
    .disp_valid(disp_valid), .disp_slot(disp_slot), .busy_hold(busy_hold),
    .list_err(list_err), .fis_err(fis_err), .d2h_req(d2h_req)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [31:0] v);
    cmd_wr_data = v;
    cmd_wr_en = 1'b1;
    step();
    cmd_wr_en = 1'b0;
  endtask

  task automatic wr_issue(input logic [31:0] v);
    issue_wr_data = v;
    issue_wr_en = 1'b1;
    step();
    issue_wr_en = 1'b0;
  endtask

  task automatic pulse_port_reset();
    port_reset = 1'b1;
    step();
    port_reset = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic t_reset();
    check("R1", "cmd_reg", cmd_reg, 32'h0);
    check("R1", "issue_vec", issue_vec, 32'h0);
    check("R1", "outputs", {27'b0, disp_valid, busy_hold, list_err, fis_err, d2h_req}, 32'h0);
  endtask

  task automatic t_fields_bad_base();
    clb_base = 64'h0;
    fis_base = 64'h0;
    wr_cmd(32'hFFFF_FFFF);
    check("R2", "cmd after all-ones", cmd_reg, 32'h0FFF_00EE);
    check("R3", "list_err pulse", {31'b0, list_err}, 32'h1);
    check("R5", "fis_err pulse", {31'b0, fis_err}, 32'h1);
    step();
    check("R3", "list_err one cycle", {31'b0, list_err}, 32'h0);
    wr_cmd(32'h0);
    check("R2", "cmd cleared", cmd_reg, 32'h0);
  endtask

  task automatic t_engines();
    clb_base = 64'h1000;
    fis_base = 64'h100;
    wr_cmd(32'h0000_0011);
    check("R3", "both running", cmd_reg, 32'h0000_C011);
    check("R6", "first d2h request", {31'b0, d2h_req}, 32'h1);
    step();
    check("R6", "d2h one cycle", {31'b0, d2h_req}, 32'h0);
    wr_cmd(32'h0000_0F11);
    check("R2", "protected bits kept", cmd_reg, 32'h0000_C011);
    check("R6", "no repeat request", {31'b0, d2h_req}, 32'h0);
    wr_cmd(32'h0000_0010);
    check("R4", "stop clears list run", cmd_reg, 32'h0000_4010);
    clb_base = 64'h1200;
    wr_cmd(32'h0000_0011);
    check("R3", "misaligned clb", cmd_reg, 32'h0000_4010);
    check("R3", "misaligned list_err", {31'b0, list_err}, 32'h1);
    clb_base = 64'h400;
    wr_cmd(32'h0000_0011);
    check("R3", "1K aligned clb", cmd_reg, 32'h0000_C011);
    wr_cmd(32'h0000_0001);
    check("R5", "disable clears fis run", cmd_reg, 32'h0000_8001);
    fis_base = 64'h180;
    wr_cmd(32'h0000_0011);
    check("R5", "misaligned fis", cmd_reg, 32'h0000_8001);
    check("R5", "fis_err pulse", {31'b0, fis_err}, 32'h1);
    fis_base = 64'h200;
    wr_cmd(32'h0000_0011);
    check("R5", "fis running again", cmd_reg, 32'h0000_C011);
    check("R6", "still suppressed", {31'b0, d2h_req}, 32'h0);
    pulse_port_reset();
    wr_cmd(32'h0000_0011);
    check("R11", "request re-armed", {31'b0, d2h_req}, 32'h1);
  endtask

  task automatic t_dispatch();
    wr_issue(32'h0000_0028);
    check("R8", "issue merged", issue_vec, 32'h0000_0028);
    check("R7", "valid", {31'b0, disp_valid}, 32'h1);
    check("R7", "lowest slot", {27'b0, disp_slot}, 32'd3);
    disp_ready = 1'b1;
    disp_queued = 1'b1;
    step();
    disp_ready = 1'b0;
    disp_queued = 1'b0;
    check("R9", "queued slot retired", issue_vec, 32'h0000_0020);
    check("R7", "next slot", {27'b0, disp_slot}, 32'd5);
    wr_issue(32'h0000_0004);
    check("R8", "or-merge keeps bit 5", issue_vec, 32'h0000_0024);
    check("R7", "lower slot preferred", {27'b0, disp_slot}, 32'd2);
  endtask

  task automatic t_busy();
    dev_bsy = 1'b1;
    disp_ready = 1'b1;
    disp_queued = 1'b0;
    step();
    disp_ready = 1'b0;
    check("R10", "busy held", {31'b0, busy_hold}, 32'h1);
    check("R10", "bit kept while busy", issue_vec, 32'h0000_0024);
    check("R10", "no dispatch while busy", {31'b0, disp_valid}, 32'h0);
    for (int i = 0; i < 3; i++) step();
    check("R10", "held under BSY", {31'b0, busy_hold}, 32'h1);
    dev_bsy = 1'b0;
    dev_drq = 1'b1;
    step();
    check("R10", "held under DRQ", {31'b0, busy_hold}, 32'h1);
    check("R10", "bit kept under DRQ", issue_vec, 32'h0000_0024);
    dev_drq = 1'b0;
    step();
    check("R10", "released clears bit", issue_vec, 32'h0000_0020);
    check("R10", "hold released", {31'b0, busy_hold}, 32'h0);
    check("R7", "resumes at slot 5", {26'b0, disp_valid, disp_slot}, 32'h0000_0025);
  endtask

  task automatic t_reset_busy();
    dev_bsy = 1'b1;
    disp_ready = 1'b1;
    step();
    disp_ready = 1'b0;
    check("R10", "slot 5 busy", {31'b0, busy_hold}, 32'h1);
    pulse_port_reset();
    check("R11", "busy released", {31'b0, busy_hold}, 32'h0);
    check("R11", "issue bit kept", issue_vec, 32'h0000_0020);
    check("R11", "re-offered", {26'b0, disp_valid, disp_slot}, 32'h0000_0025);
    dev_bsy = 1'b0;
    wr_cmd(32'h0000_0010);
    check("R7", "stopped list gates dispatch", {31'b0, disp_valid}, 32'h0);
    check("R8", "issue kept when stopped", issue_vec, 32'h0000_0020);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_fields_bad_base();
    t_engines();
    t_dispatch();
    t_busy();
    t_reset_busy();
    done = 1;
    summary();
    $finish;
  end
endmodule